// File: doc/BRIEF.md
# Auto-Reload Sub-Second Interval Alarm

This block raises a periodic alarm from a slow 256 Hz tick. Software programs an interval value (8 bits by default, up to 16 bits) and sets an enable bit. The enable does not act at once. It takes effect at the next tick, and a busy status stays high until then. From that tick on, a down-counter counts ticks. Each time the counter rolls over, it reloads itself from the interval value and sets a sticky alarm flag. The interval between alarms therefore never drifts. Only the first interval after enabling is offset, by the wait for the synchronising tick.

The tick input must be taken from the clock divider before any trim pulses are inserted or removed. Trim corrections then never stretch or shorten an interval. An interval value of zero selects the longest interval, 2^width ticks. The sticky flag feeds an interrupt output, gated by a local enable. The interrupt in turn feeds a wakeup output, gated by a global interrupt enable.

Top module: `subsec_alarm`

## Requirements
- R1: After reset, enable_o, busy_o, flag_o, irq_o and wake_o are 0 and interval_o is 0.
- R2: A write on en_wr_i updates enable_o on the next clock. busy_o is 1 whenever enable_o differs from the state that has been synchronised. Synchronisation happens at the first tick256_i pulse that comes in a cycle after the write, so a tick in the same cycle as the write does not count.
- R3: A write on ivl_wr_i updates interval_o on the next clock only if enable_o is 0 and busy_o is 0 in that cycle. Otherwise the write is ignored and interval_o keeps its value.
- R4: Let N be the interval value. After the tick that synchronises an enable, the first alarm sets flag_o on the N-th following tick, and flag_o is visible one clock after that tick.
- R5: While the alarm stays enabled, the counter reloads the interval value only on rollover, so each later alarm comes exactly N ticks after the previous one.
- R6: An interval value of 0 gives N = 2^CNT_W ticks, which is 256 for the default width of 8.
- R7: flag_o is sticky. A flag_clr_i pulse clears it on the next clock, but an alarm in the same cycle as the clear leaves it set.
- R8: irq_o is flag AND irq_en_i, and wake_o is that value AND wake_gate_i. Both are registered and follow their inputs one clock later.
- R9: Once a disable has been synchronised, ticks do not change flag_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick256_i | input | 1 | One-cycle pulse at 256 Hz, untrimmed |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_wdata_i | input | 1 | Enable value to write |
| ivl_wr_i | input | 1 | Write strobe for the interval value |
| ivl_wdata_i | input | CNT_W | Interval value to write |
| flag_clr_i | input | 1 | Clears the sticky alarm flag |
| irq_en_i | input | 1 | Local interrupt enable |
| wake_gate_i | input | 1 | Global interrupt enable, gates the wakeup |
| enable_o | output | 1 | Enable bit as written |
| busy_o | output | 1 | Enable change not yet synchronised |
| interval_o | output | CNT_W | Current interval value |
| flag_o | output | 1 | Sticky alarm flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
A wrong count or reload shows up as flag_o rising one or more ticks early or late. The bench checks flag_o after every tick, so an off-by-one is caught at the first alarm (a faulty load) or at the second (a faulty reload). Faults in the enable synchroniser show up at busy_o within one tick of the write. A bad write lock shows up on interval_o on the clock after the blocked write. Faults in the flag gating appear on irq_o or wake_o one clock after the gate input changes.

// File: rtl/subsec_alarm_pkg.sv
package subsec_alarm_pkg;

    localparam int unsigned SSA_MAX_W = 16;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_LOAD   = 2'd1,
        OP_STEP   = 2'd2,
        OP_RELOAD = 2'd3
    } cnt_op_e;

endpackage

// File: rtl/ssa_ctrl.sv
module ssa_ctrl #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             en_wr_i,
    input  logic             en_wdata_i,
    input  logic             ivl_wr_i,
    input  logic [CNT_W-1:0] ivl_wdata_i,
    output logic             enable_o,
    output logic             busy_o,
    output logic [CNT_W-1:0] interval_o,
    output logic             load_o,
    output logic             step_o
);

    typedef struct packed {
        logic             ase;
        logic             run;
        logic             busy;
        logic [CNT_W-1:0] ivl;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_wr_i) begin
            st_d.ase = en_wdata_i;
        end
        // the running state only follows the written enable on a tick
        if (tick_i) begin
            st_d.run = st_q.ase;
        end
        st_d.busy = (st_d.ase != st_d.run);
        if (ivl_wr_i && !st_q.ase && !st_q.busy) begin
            st_d.ivl = ivl_wdata_i;
        end
        load_o = tick_i && st_q.ase && !st_q.run;
        step_o = tick_i && st_q.ase && st_q.run;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign enable_o   = st_q.ase;
    assign busy_o     = st_q.busy;
    assign interval_o = st_q.ivl;

endmodule

// File: rtl/ssa_counter.sv
module ssa_counter
    import subsec_alarm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             rollover_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t    st_d, st_q;
    cnt_op_e op;

    always_comb begin
        op = OP_HOLD;
        if (load_i) begin
            op = OP_LOAD;
        end else if (step_i) begin
            op = (st_q.cnt == CNT_W'(1)) ? OP_RELOAD : OP_STEP;
        end

        st_d = st_q;
        unique case (op)
            OP_LOAD, OP_RELOAD: st_d.cnt = reload_i;
            OP_STEP:            st_d.cnt = st_q.cnt - CNT_W'(1);
            default:            st_d.cnt = st_q.cnt;
        endcase
        rollover_o = (op == OP_RELOAD);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ssa_flag.sv
module ssa_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic alarm_i,
    input  logic clr_i,
    input  logic irq_en_i,
    input  logic wake_gate_i,
    output logic flag_o,
    output logic irq_o,
    output logic wake_o
);

    typedef struct packed {
        logic flag;
        logic irq;
        logic wake;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.flag = 1'b0;
        end
        // a new alarm wins over a clear in the same cycle
        if (alarm_i) begin
            st_d.flag = 1'b1;
        end
        st_d.irq  = st_d.flag && irq_en_i;
        st_d.wake = st_d.irq && wake_gate_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.irq;
    assign wake_o = st_q.wake;

endmodule

// File: rtl/subsec_alarm.sv
module subsec_alarm
    import subsec_alarm_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick256_i,
    input  logic             en_wr_i,
    input  logic             en_wdata_i,
    input  logic             ivl_wr_i,
    input  logic [CNT_W-1:0] ivl_wdata_i,
    input  logic             flag_clr_i,
    input  logic             irq_en_i,
    input  logic             wake_gate_i,
    output logic             enable_o,
    output logic             busy_o,
    output logic [CNT_W-1:0] interval_o,
    output logic             flag_o,
    output logic             irq_o,
    output logic             wake_o
);

    if (CNT_W < 1 || CNT_W > SSA_MAX_W) begin : g_bad_width
        $error("CNT_W out of range");
    end

    logic load;
    logic step;
    logic rollover;

    ssa_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick256_i),
        .en_wr_i     (en_wr_i),
        .en_wdata_i  (en_wdata_i),
        .ivl_wr_i    (ivl_wr_i),
        .ivl_wdata_i (ivl_wdata_i),
        .enable_o    (enable_o),
        .busy_o      (busy_o),
        .interval_o  (interval_o),
        .load_o      (load),
        .step_o      (step)
    );

    ssa_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load),
        .step_i     (step),
        .reload_i   (interval_o),
        .rollover_o (rollover)
    );

    ssa_flag u_flag (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .alarm_i     (rollover),
        .clr_i       (flag_clr_i),
        .irq_en_i    (irq_en_i),
        .wake_gate_i (wake_gate_i),
        .flag_o      (flag_o),
        .irq_o       (irq_o),
        .wake_o      (wake_o)
    );

endmodule

// File: rtl/subsec_alarm_chk.sv
module subsec_alarm_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             tick256_i,
    input logic             en_wr_i,
    input logic             ivl_wr_i,
    input logic             flag_clr_i,
    input logic             enable_o,
    input logic             busy_o,
    input logic [CNT_W-1:0] interval_o,
    input logic             flag_o,
    input logic             irq_o,
    input logic             wake_o
);

    AST_BUSY_RISES_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(en_wr_i)); // R2
    AST_BUSY_FALLS_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> ($past(tick256_i) || $past(en_wr_i))); // R2
    AST_IVL_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ivl_wr_i && (enable_o || busy_o)) |=> $stable(interval_o)); // R3
    AST_IVL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ivl_wr_i |=> $stable(interval_o)); // R3
    AST_ALARM_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_o) |-> ($past(tick256_i) && $past(enable_o) && !$past(busy_o))); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !flag_clr_i) |=> flag_o); // R7
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> flag_o); // R8
    AST_WAKE_NEEDS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_o |-> irq_o); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!enable_o && !busy_o && !flag_o) |=> !flag_o); // R9

endmodule

bind subsec_alarm subsec_alarm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick256_i  (tick256_i),
    .en_wr_i    (en_wr_i),
    .ivl_wr_i   (ivl_wr_i),
    .flag_clr_i (flag_clr_i),
    .enable_o   (enable_o),
    .busy_o     (busy_o),
    .interval_o (interval_o),
    .flag_o     (flag_o),
    .irq_o      (irq_o),
    .wake_o     (wake_o)
);

// File: tb/subsec_alarm_bench.sv
`timescale 1ns/1ps
module subsec_alarm_bench;

    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         en_wr = 1'b0;
    logic         en_wdata = 1'b0;
    logic         ivl_wr = 1'b0;
    logic [W-1:0] ivl_wdata = '0;
    logic         flag_clr = 1'b0;
    logic         irq_en = 1'b0;
    logic         wake_gate = 1'b0;
    logic         enable_o, busy_o, flag_o, irq_o, wake_o;
    logic [W-1:0] interval_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    subsec_alarm #(.CNT_W(W)) u_subsec_alarm (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .tick256_i   (tick),
        .en_wr_i     (en_wr),
        .en_wdata_i  (en_wdata),
        .ivl_wr_i    (ivl_wr),
        .ivl_wdata_i (ivl_wdata),
        .flag_clr_i  (flag_clr),
        .irq_en_i    (irq_en),
        .wake_gate_i (wake_gate),
        .enable_o    (enable_o),
        .busy_o      (busy_o),
        .interval_o  (interval_o),
        .flag_o      (flag_o),
        .irq_o       (irq_o),
        .wake_o      (wake_o)
    );

    function automatic int ivl_ticks(input int v);
        return (v == 0) ? (1 << W) : v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr_en(input bit v);
        @(negedge clk); en_wr = 1'b1; en_wdata = v;
        @(negedge clk); en_wr = 1'b0;
    endtask

    task automatic wr_ivl(input int v);
        @(negedge clk); ivl_wr = 1'b1; ivl_wdata = W'(v);
        @(negedge clk); ivl_wr = 1'b0;
    endtask

    task automatic do_tick();
        repeat ($urandom_range(0, 2)) @(negedge clk);
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic do_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic run_case(input int v, input int reps);
        int n;
        n = ivl_ticks(v);
        wr_ivl(v);
        check("R3 interval accepted when idle", int'(interval_o), v & ((1 << W) - 1));
        wr_en(1'b1);
        check("R2 enable visible", int'(enable_o), 1);
        check("R2 busy after enable", int'(busy_o), 1);
        do_tick();
        check("R2 busy cleared at tick", int'(busy_o), 0);
        check("R4 no flag at sync tick", int'(flag_o), 0);
        for (int r = 0; r < reps; r++) begin
            for (int k = 1; k <= n; k++) begin
                do_tick();
                if (v == 0)
                    check("R6 zero interval timing", int'(flag_o), int'(k == n));
                else if (r == 0)
                    check("R4 first alarm timing", int'(flag_o), int'(k == n));
                else
                    check("R5 reload alarm timing", int'(flag_o), int'(k == n));
            end
            do_clr();
            check("R7 clear", int'(flag_o), 0);
        end
        wr_en(1'b0);
        check("R2 busy after disable", int'(busy_o), 1);
        do_tick();
        check("R2 busy cleared after disable", int'(busy_o), 0);
        for (int k = 0; k < n + 2; k++) begin
            do_tick();
            if (k < 4 || k == n || k == n + 1)
                check("R9 no alarm when disabled", int'(flag_o), 0);
        end
    endtask

    initial begin
        void'($urandom(32'h5A17));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 enable reset", int'(enable_o), 0);
        check("R1 busy reset", int'(busy_o), 0);
        check("R1 flag reset", int'(flag_o), 0);
        check("R1 irq reset", int'(irq_o), 0);
        check("R1 wake reset", int'(wake_o), 0);
        check("R1 interval reset", int'(interval_o), 0);

        // directed corner intervals
        run_case(1, 3);
        run_case(0, 2);
        run_case(255, 1);
        // random intervals
        for (int i = 0; i < 4; i++) begin
            run_case(int'($urandom_range(2, 40)), 2);
        end

        // R2: tick in the write cycle does not synchronise
        wr_ivl(5);
        @(negedge clk); en_wr = 1'b1; en_wdata = 1'b1; tick = 1'b1;
        @(negedge clk); en_wr = 1'b0; tick = 1'b0;
        check("R2 same-cycle tick ignored", int'(busy_o), 1);
        wr_ivl(9);
        check("R3 write blocked while busy", int'(interval_o), 5);
        do_tick();
        check("R2 synchronised", int'(busy_o), 0);
        wr_ivl(9);
        check("R3 write blocked while enabled", int'(interval_o), 5);
        for (int k = 1; k <= 5; k++) begin
            do_tick();
            check("R4 alarm after late sync", int'(flag_o), int'(k == 5));
        end
        do_clr();
        wr_en(1'b0);
        wr_ivl(9);
        check("R3 write blocked while disable pending", int'(interval_o), 5);
        do_tick();
        wr_ivl(9);
        check("R3 write accepted after disable", int'(interval_o), 9);

        // R7 / R8: flag gating and set-over-clear
        wr_ivl(1);
        wr_en(1'b1);
        do_tick();
        do_tick();
        check("R4 interval one", int'(flag_o), 1);
        @(negedge clk); wake_gate = 1'b1;
        @(negedge clk);
        check("R8 irq masked", int'(irq_o), 0);
        check("R8 wake masked", int'(wake_o), 0);
        irq_en = 1'b1;
        @(negedge clk);
        check("R8 irq on", int'(irq_o), 1);
        check("R8 wake on", int'(wake_o), 1);
        wake_gate = 1'b0;
        @(negedge clk);
        check("R8 wake gated", int'(wake_o), 0);
        check("R8 irq kept", int'(irq_o), 1);
        flag_clr = 1'b1; tick = 1'b1;
        @(negedge clk); flag_clr = 1'b0; tick = 1'b0;
        check("R7 alarm wins over clear", int'(flag_o), 1);
        do_clr();
        check("R7 clear alone", int'(flag_o), 0);
        @(negedge clk);
        check("R8 irq follows clear", int'(irq_o), 0);
        wr_en(1'b0);
        do_tick();

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule